// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block carries out the full link bring-up handshake between a DisplayPort source and its sink. A single `start` pulse launches the sequence. The block first writes the link configuration into the sink. It then runs a clock-recovery phase on training pattern 1 and an equalisation phase on training pattern 2 or 3. A closing step switches the patterns off again. The sink is reached through an abstract register request port: one request per write or status read, each completed by an acknowledge. The source PHY is reached through a command port with the same request/acknowledge pairing.

When the sink asks for more drive, the block collects the per-lane swing and pre-emphasis requests from every active lane. It keeps the largest of each, marks any that sit at level 3 as at maximum, and programs that one byte into both the PHY and the sink. Every delay is counted in ticks of the `us_tick` input, one tick per microsecond. When the run ends, `done` rises. `pass` then reports success, and `fail_code` tells which abort condition ended the run.

Top module: `lt_link_trainer`

## Requirements
- R1: After reset, `done`, `pass` and `fail_code` are 0, and neither `sreg_req` nor `phy_req` is raised until `start` is seen.
- R2: Setup issues, in this order: sink write 0x600←0x01 (power on); 0x107←0x10 if `cap_spread` else 0x00; 0x101←{`cap_enh_frame` in bit 7, lane count in bits 2:0}; 0x100←`rate_code`; PHY command START (code 0); sink write 0x102←0x00.
- R3: Clock recovery then issues PHY PAT1 (code 1), sink 0x102←0x01, PHY DRIVE (code 4) with `phy_drive`=0x00, and sink 0x103←0x00. The first status read (address 0x202) comes no sooner than SETTLE_US+CR_US ticks later.
- R4: The drive byte holds voltage in bits 1:0, a max-swing flag in bit 2, pre-emphasis in bits 4:3 and a max-pre-emphasis flag in bit 5. It is the maximum over active lanes of the requests in `sts_adj` (lane i: voltage [4i+1:4i], pre-emphasis [4i+3:4i+2]). Each flag is set when its level is 3. Lanes at or above `lane_cnt` are ignored.
- R5: Clock recovery succeeds when `sts_cr` is set for every active lane. Inactive lanes do not matter.
- R6: If a failing clock-recovery read finds max-swing set in the current drive byte, the run fails with code 1.
- R7: If the voltage of the current drive equals that of the previous failing read on 5 consecutive reads, the run fails with code 2. With a constant request of 0, this happens on the 6th read.
- R8: Equalisation issues PHY PAT3 (code 3) and sink 0x102←0x03 when `cap_tps3` is set, and otherwise PAT2 (code 2) and 0x102←0x02.
- R9: Equalisation succeeds when every active lane has both `sts_cr` and `sts_eq` set. Each failing read re-applies the merged drive. The 7th failing read ends the run with code 3.
- R10: A status read acknowledged with `sreg_err` ends the current phase with code 4.
- R11: The finish step always runs. After at least SETTLE_US ticks it issues sink 0x102←0x00 and then PHY COMPLETE (code 5). `done` then rises, with `pass`=1 exactly when `fail_code`=0.
- R12: A `start` pulse during a run is ignored. A request holds its address, data and command steady until it is acknowledged.
- R13: Wait counters advance only on `us_tick`. With the tick held low, no status read is ever issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Launch a training run |
| lane_cnt | input | $clog2(LANES)+1 | Active lane count (1, 2 or 4) |
| rate_code | input | 8 | Link rate code written to the sink |
| cap_spread | input | 1 | Sink supports downspread |
| cap_enh_frame | input | 1 | Sink supports enhanced framing |
| cap_tps3 | input | 1 | Sink supports training pattern 3 |
| sreg_req | output | 1 | Sink register request pending |
| sreg_wr | output | 1 | 1 = write, 0 = status read |
| sreg_addr | output | 12 | Sink register address |
| sreg_wdata | output | 8 | Write data |
| sreg_ack | input | 1 | Request completed |
| sreg_err | input | 1 | Status read failed (valid with ack) |
| sts_cr | input | LANES | Per-lane clock-recovery-done bits (valid with ack) |
| sts_eq | input | LANES | Per-lane equalisation-done bits (valid with ack) |
| sts_adj | input | 4*LANES | Per-lane drive requests (valid with ack) |
| phy_req | output | 1 | PHY command pending |
| phy_cmd | output | 3 | 0 START, 1 PAT1, 2 PAT2, 3 PAT3, 4 DRIVE, 5 COMPLETE |
| phy_drive | output | 8 | Drive byte for the DRIVE command |
| phy_ack | input | 1 | PHY command completed |
| done | output | 1 | Run finished (held until next start) |
| pass | output | 1 | Run succeeded |
| fail_code | output | 3 | 0 none, 1 max swing, 2 repeated voltage, 3 equalisation timeout, 4 status read error |

## Verification
A corrupted retry counter or a stale previous-voltage register shows up at the ports as a wrong count of 0x202 reads before `done` and as a wrong `fail_code`. The error becomes visible within one status-read interval of the slip. A bad merge shows up in the very next 0x103 write and DRIVE command. A phase register stuck in the wrong phase shows up as a missing or wrong pattern write before the next read. A timer fault moves the spacing between the drive write and the next read, or between the last read and the closing pattern-off write, at once.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_PWR, ST_SPREAD, ST_LANES, ST_RATE, ST_SRC_GO, ST_PAT_OFF,
    ST_CR_SRC, ST_CR_SNK, ST_DRV_SRC, ST_DRV_SNK, ST_WAIT, ST_READ,
    ST_EQ_SRC, ST_EQ_SNK, ST_FIN_WAIT, ST_FIN_SNK, ST_FIN_SRC
  } lt_state_e;

  typedef enum logic [2:0] {
    PHY_START = 3'd0, PHY_PAT1 = 3'd1, PHY_PAT2 = 3'd2, PHY_PAT3 = 3'd3,
    PHY_DRIVE = 3'd4, PHY_COMPLETE = 3'd5
  } phy_cmd_e;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0, FC_MAX_SWING = 3'd1, FC_REPEAT = 3'd2,
    FC_EQ_TIMEOUT = 3'd3, FC_READ_ERR = 3'd4
  } fail_e;

  localparam logic [11:0] A_RATE     = 12'h100;
  localparam logic [11:0] A_LANES    = 12'h101;
  localparam logic [11:0] A_PAT      = 12'h102;
  localparam logic [11:0] A_LANE_SET = 12'h103;
  localparam logic [11:0] A_SPREAD   = 12'h107;
  localparam logic [11:0] A_STATUS   = 12'h202;
  localparam logic [11:0] A_POWER    = 12'h600;
  localparam logic [7:0]  SPREAD_ON  = 8'h10;
endpackage

// File: rtl/lt_drive_merge.sv
module lt_drive_merge #(
  parameter int LANES = 4,
  parameter int LCW   = 3
) (
  input  logic [4*LANES-1:0] adj,
  input  logic [LCW-1:0]     lane_cnt,
  output logic [7:0]         lane_set
);
  logic [1:0] v_max, p_max;

  always_comb begin
    v_max = 2'd0;
    p_max = 2'd0;
    for (int i = 0; i < LANES; i++) begin
      if (LCW'(i) < lane_cnt) begin
        if (adj[4*i +: 2] > v_max)     v_max = adj[4*i +: 2];
        if (adj[4*i + 2 +: 2] > p_max) p_max = adj[4*i + 2 +: 2];
      end
    end
    lane_set = {2'b00, (p_max == 2'd3), p_max, (v_max == 2'd3), v_max};
  end

  // R4: merged levels dominate every active lane request
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (LCW'(i) < lane_cnt) begin
        p_merge_covers_r4: assert (lane_set[1:0] >= adj[4*i +: 2] &&
                                   lane_set[4:3] >= adj[4*i + 2 +: 2]);
      end
    end
  end
endmodule

// File: rtl/lt_us_timer.sv
module lt_us_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  input  logic          tick,
  output logic          expired
);
  logic [TW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (load)                     cnt_n = len;
    else if (tick && cnt != '0)   cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign expired = (cnt == '0);

  p_tick_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/lt_link_trainer.sv
module lt_link_trainer
  import lt_pkg::*;
#(
  parameter int LANES        = 4,
  parameter int SETTLE_US    = 400,
  parameter int CR_US        = 100,
  parameter int EQ_US        = 400,
  parameter int REPEAT_LIMIT = 5,
  parameter int EQ_LIMIT     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   us_tick,
  input  logic                   start,
  input  logic [$clog2(LANES):0] lane_cnt,
  input  logic [7:0]             rate_code,
  input  logic                   cap_spread,
  input  logic                   cap_enh_frame,
  input  logic                   cap_tps3,
  output logic                   sreg_req,
  output logic                   sreg_wr,
  output logic [11:0]            sreg_addr,
  output logic [7:0]             sreg_wdata,
  input  logic                   sreg_ack,
  input  logic                   sreg_err,
  input  logic [LANES-1:0]       sts_cr,
  input  logic [LANES-1:0]       sts_eq,
  input  logic [4*LANES-1:0]     sts_adj,
  output logic                   phy_req,
  output logic [2:0]             phy_cmd,
  output logic [7:0]             phy_drive,
  input  logic                   phy_ack,
  output logic                   done,
  output logic                   pass,
  output logic [2:0]             fail_code
);
  localparam int LCW   = $clog2(LANES) + 1;
  localparam int LIMX  = (REPEAT_LIMIT > EQ_LIMIT) ? REPEAT_LIMIT : EQ_LIMIT;
  localparam int TRW   = $clog2(LIMX + 2);
  localparam int TW    = $clog2(SETTLE_US + CR_US + EQ_US + 1);

  lt_state_e        state, state_n;
  logic [7:0]       drive, drive_n, merged;
  logic [TRW-1:0]   tries, tries_n;
  logic [1:0]       prev_v, prev_v_n;
  logic             prev_vld, prev_vld_n, eq_ph, eq_ph_n, first, first_n;
  logic [LCW-1:0]   lanes_q, lanes_n;
  logic [7:0]       rate_q, rate_n;
  logic             sp_q, sp_n, enh_q, enh_n, tps3_q, tps3_n;
  logic             done_n, pass_n;
  fail_e            code, code_n;
  logic [LANES-1:0] lane_mask;
  logic             cr_all, eq_all, wait_load, wait_exp;
  logic [TW-1:0]    wait_len;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g] = (LCW'(g) < lanes_q);
  end

  assign cr_all = &(sts_cr | ~lane_mask);
  assign eq_all = &((sts_cr & sts_eq) | ~lane_mask);

  lt_drive_merge #(.LANES(LANES), .LCW(LCW)) u_merge (
    .adj(sts_adj), .lane_cnt(lanes_q), .lane_set(merged));

  always_comb begin
    state_n = state;     drive_n = drive;     tries_n = tries;
    prev_v_n = prev_v;   prev_vld_n = prev_vld;
    eq_ph_n = eq_ph;     first_n = first;     code_n = code;
    lanes_n = lanes_q;   rate_n = rate_q;     sp_n = sp_q;
    enh_n = enh_q;       tps3_n = tps3_q;     done_n = done;   pass_n = pass;
    case (state)
      ST_IDLE: if (start) begin
        lanes_n = lane_cnt; rate_n = rate_code; sp_n = cap_spread;
        enh_n = cap_enh_frame; tps3_n = cap_tps3;
        done_n = 1'b0; pass_n = 1'b0; code_n = FC_NONE; state_n = ST_PWR;
      end
      ST_PWR:     if (sreg_ack) state_n = ST_SPREAD;
      ST_SPREAD:  if (sreg_ack) state_n = ST_LANES;
      ST_LANES:   if (sreg_ack) state_n = ST_RATE;
      ST_RATE:    if (sreg_ack) state_n = ST_SRC_GO;
      ST_SRC_GO:  if (phy_ack)  state_n = ST_PAT_OFF;
      ST_PAT_OFF: if (sreg_ack) state_n = ST_CR_SRC;
      ST_CR_SRC:  if (phy_ack)  state_n = ST_CR_SNK;
      ST_CR_SNK:  if (sreg_ack) begin
        drive_n = 8'h00; tries_n = '0; prev_vld_n = 1'b0;
        eq_ph_n = 1'b0;  first_n = 1'b1; state_n = ST_DRV_SRC;
      end
      ST_DRV_SRC: if (phy_ack)  state_n = ST_DRV_SNK;
      ST_DRV_SNK: if (sreg_ack) state_n = ST_WAIT;
      ST_WAIT:    if (wait_exp) begin first_n = 1'b0; state_n = ST_READ; end
      ST_READ: if (sreg_ack) begin
        if (sreg_err) begin
          code_n = FC_READ_ERR; state_n = ST_FIN_WAIT;
        end else if (!eq_ph) begin
          if (cr_all) state_n = ST_EQ_SRC;
          else if (drive[2]) begin
            code_n = FC_MAX_SWING; state_n = ST_FIN_WAIT;
          end else begin
            if (prev_vld && prev_v == drive[1:0]) tries_n = tries + 1'b1;
            else                                  tries_n = '0;
            if (prev_vld && prev_v == drive[1:0] &&
                tries + 1'b1 == TRW'(REPEAT_LIMIT)) begin
              code_n = FC_REPEAT; state_n = ST_FIN_WAIT;
            end else begin
              prev_v_n = drive[1:0]; prev_vld_n = 1'b1;
              drive_n = merged; state_n = ST_DRV_SRC;
            end
          end
        end else begin
          if (eq_all) state_n = ST_FIN_WAIT;
          else if (tries > TRW'(EQ_LIMIT)) begin
            code_n = FC_EQ_TIMEOUT; state_n = ST_FIN_WAIT;
          end else begin
            drive_n = merged; tries_n = tries + 1'b1; state_n = ST_DRV_SRC;
          end
        end
      end
      ST_EQ_SRC: if (phy_ack) state_n = ST_EQ_SNK;
      ST_EQ_SNK: if (sreg_ack) begin
        tries_n = '0; eq_ph_n = 1'b1; state_n = ST_WAIT;
      end
      ST_FIN_WAIT: if (wait_exp) state_n = ST_FIN_SNK;
      ST_FIN_SNK:  if (sreg_ack) state_n = ST_FIN_SRC;
      ST_FIN_SRC:  if (phy_ack) begin
        done_n = 1'b1; pass_n = (code == FC_NONE); state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; drive <= '0; tries <= '0; prev_v <= '0;
      prev_vld <= 1'b0; eq_ph <= 1'b0; first <= 1'b0; code <= FC_NONE;
      lanes_q <= '0; rate_q <= '0; sp_q <= 1'b0; enh_q <= 1'b0;
      tps3_q <= 1'b0; done <= 1'b0; pass <= 1'b0;
    end else begin
      state <= state_n; drive <= drive_n; tries <= tries_n; prev_v <= prev_v_n;
      prev_vld <= prev_vld_n; eq_ph <= eq_ph_n; first <= first_n; code <= code_n;
      lanes_q <= lanes_n; rate_q <= rate_n; sp_q <= sp_n; enh_q <= enh_n;
      tps3_q <= tps3_n; done <= done_n; pass <= pass_n;
    end
  end

  assign wait_load = (state_n != state) &&
                     (state_n == ST_WAIT || state_n == ST_FIN_WAIT);
  always_comb begin
    if (state_n == ST_FIN_WAIT) wait_len = TW'(SETTLE_US);
    else if (eq_ph_n)           wait_len = TW'(EQ_US);
    else if (first_n)           wait_len = TW'(SETTLE_US + CR_US);
    else                        wait_len = TW'(CR_US);
  end

  lt_us_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(wait_load), .len(wait_len),
    .tick(us_tick), .expired(wait_exp));

  always_comb begin
    sreg_req = 1'b1; sreg_wr = 1'b1; sreg_addr = A_PAT; sreg_wdata = 8'h00;
    phy_req = 1'b0;  phy_cmd = PHY_START;
    case (state)
      ST_PWR:     begin sreg_addr = A_POWER;  sreg_wdata = 8'h01; end
      ST_SPREAD:  begin sreg_addr = A_SPREAD; sreg_wdata = sp_q ? SPREAD_ON : 8'h00; end
      ST_LANES:   begin sreg_addr = A_LANES;
                        sreg_wdata = {enh_q, {(7-LCW){1'b0}}, lanes_q}; end
      ST_RATE:    begin sreg_addr = A_RATE;   sreg_wdata = rate_q; end
      ST_PAT_OFF, ST_FIN_SNK: sreg_wdata = 8'h00;
      ST_CR_SNK:  sreg_wdata = 8'h01;
      ST_EQ_SNK:  sreg_wdata = tps3_q ? 8'h03 : 8'h02;
      ST_DRV_SNK: begin sreg_addr = A_LANE_SET; sreg_wdata = drive; end
      ST_READ:    begin sreg_wr = 1'b0; sreg_addr = A_STATUS; end
      default: begin
        sreg_req = 1'b0;
        phy_req  = (state != ST_IDLE && state != ST_WAIT && state != ST_FIN_WAIT);
        case (state)
          ST_CR_SRC:  phy_cmd = PHY_PAT1;
          ST_EQ_SRC:  phy_cmd = tps3_q ? PHY_PAT3 : PHY_PAT2;
          ST_DRV_SRC: phy_cmd = PHY_DRIVE;
          ST_FIN_SRC: phy_cmd = PHY_COMPLETE;
          default:    phy_cmd = PHY_START;
        endcase
      end
    endcase
  end

  assign phy_drive = drive;
  assign fail_code = code;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sreg_req && !phy_req));
  p_sreg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg_req && !sreg_ack) |=> (sreg_req && $stable(sreg_addr) &&
                                 $stable(sreg_wdata) && $stable(sreg_wr)));
  p_phy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_ack) |=> (phy_req && $stable(phy_cmd) && $stable(phy_drive)));
  p_pass_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (fail_code == 3'd0));
  p_repeat_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && !eq_ph) |-> (tries < TRW'(REPEAT_LIMIT)));
  p_one_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sreg_req && phy_req));
endmodule

// File: tb/sim_lt_link_trainer.sv
module sim_lt_link_trainer;
  typedef struct packed {
    logic [2:0] lanes; logic sp; logic enh; logic tps3; logic [2:0] kind;
    logic [7:0] rate; logic xpass; logic [2:0] code; logic [7:0] reads;
    logic [7:0] drv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 1'b1, 1'b1, 1'b1, 3'd0, 8'h0A, 1'b1, 3'd0, 8'd2, 8'h00},
    '{3'd2, 1'b0, 1'b1, 1'b0, 3'd1, 8'h06, 1'b0, 3'd2, 8'd6, 8'h00},
    '{3'd1, 1'b1, 1'b0, 1'b0, 3'd2, 8'h14, 1'b0, 3'd1, 8'd2, 8'h0F},
    '{3'd4, 1'b0, 1'b0, 1'b0, 3'd3, 8'h0A, 1'b0, 3'd3, 8'd8, 8'h11},
    '{3'd2, 1'b1, 1'b1, 1'b1, 3'd4, 8'h06, 1'b0, 3'd4, 8'd1, 8'h00},
    '{3'd2, 1'b0, 1'b0, 1'b1, 3'd5, 8'h14, 1'b1, 3'd0, 8'd2, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b1, start = 1'b0;
  logic [2:0] lane_cnt = 3'd4;
  logic [7:0] rate_code = 8'h0A;
  logic cap_spread = 1'b0, cap_enh_frame = 1'b0, cap_tps3 = 1'b0;
  logic sreg_req, sreg_wr, phy_req, done, pass;
  logic [11:0] sreg_addr;
  logic [7:0] sreg_wdata, phy_drive;
  logic [2:0] phy_cmd, fail_code;
  logic sreg_ack = 1'b0, sreg_err = 1'b0, phy_ack = 1'b0;
  logic [3:0] sts_cr = '0, sts_eq = '0;
  logic [15:0] sts_adj = '0;

  logic [3:0]  scr_cr [16], scr_eq [16];
  logic [15:0] scr_adj [16];
  logic        scr_err [16];
  logic [21:0] lg [128];
  int          lg_cyc [128];
  int lg_n = 0, rd_idx = 0, cyc = 0, checks = 0, fails = 0;

  always #5 clk = ~clk;

  lt_link_trainer u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
    .lane_cnt(lane_cnt), .rate_code(rate_code), .cap_spread(cap_spread),
    .cap_enh_frame(cap_enh_frame), .cap_tps3(cap_tps3),
    .sreg_req(sreg_req), .sreg_wr(sreg_wr), .sreg_addr(sreg_addr),
    .sreg_wdata(sreg_wdata), .sreg_ack(sreg_ack), .sreg_err(sreg_err),
    .sts_cr(sts_cr), .sts_eq(sts_eq), .sts_adj(sts_adj),
    .phy_req(phy_req), .phy_cmd(phy_cmd), .phy_drive(phy_drive),
    .phy_ack(phy_ack), .done(done), .pass(pass), .fail_code(fail_code));

  function automatic logic [21:0] ev(logic [1:0] k, logic [11:0] a, logic [7:0] d);
    return {k, a, d};
  endfunction

  // Sink and PHY responders: one acknowledge per request, logged in order.
  always @(negedge clk) begin
    if (sreg_ack || phy_ack) begin
      sreg_ack = 1'b0; phy_ack = 1'b0;
    end else if (sreg_req) begin
      if (lg_n < 128) begin
        lg[lg_n] = ev(sreg_wr ? 2'd0 : 2'd1, sreg_addr, sreg_wr ? sreg_wdata : 8'h00);
        lg_cyc[lg_n] = cyc; lg_n++;
      end
      if (!sreg_wr) begin
        sts_cr = scr_cr[rd_idx > 15 ? 15 : rd_idx];
        sts_eq = scr_eq[rd_idx > 15 ? 15 : rd_idx];
        sts_adj = scr_adj[rd_idx > 15 ? 15 : rd_idx];
        sreg_err = scr_err[rd_idx > 15 ? 15 : rd_idx];
        rd_idx++;
      end else sreg_err = 1'b0;
      sreg_ack = 1'b1;
    end else if (phy_req) begin
      if (lg_n < 128) begin
        lg[lg_n] = ev(2'd2, {9'd0, phy_cmd}, (phy_cmd == 3'd4) ? phy_drive : 8'h00);
        lg_cyc[lg_n] = cyc; lg_n++;
      end
      phy_ack = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string code_req(logic [2:0] c);
    case (c)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic load_script(logic [2:0] kind);
    for (int i = 0; i < 16; i++) begin
      scr_err[i] = 1'b0; scr_adj[i] = 16'h0000;
      scr_cr[i] = 4'h0;  scr_eq[i] = 4'h0;
      case (kind)
        3'd0: begin scr_cr[i] = 4'hF; scr_eq[i] = (i == 0) ? 4'h0 : 4'hF; end
        3'd2: scr_adj[i] = 16'hC007;
        3'd3: begin scr_cr[i] = 4'hF; scr_adj[i] = 16'h0081; end
        3'd4: scr_err[i] = 1'b1;
        3'd5: begin scr_cr[i] = 4'b0011; scr_eq[i] = 4'b0011; end
        default: ;
      endcase
    end
  endtask

  task automatic launch(vec_t v);
    load_script(v.kind);
    @(negedge clk);
    lg_n = 0; rd_idx = 0;
    lane_cnt = v.lanes; rate_code = v.rate; cap_spread = v.sp;
    cap_enh_frame = v.enh; cap_tps3 = v.tps3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 30000 && !done; n++) @(negedge clk);
  endtask

  task automatic check_run(vec_t v);
    logic [21:0] exp_setup [10];
    int reads = 0, first_rd = -1, last_rd = -1, last_drv = -1, drv_w = -1, pat_i = -1;
    bit ok;
    exp_setup[0] = ev(0, 12'h600, 8'h01);
    exp_setup[1] = ev(0, 12'h107, v.sp ? 8'h10 : 8'h00);
    exp_setup[2] = ev(0, 12'h101, {v.enh, 4'b0000, v.lanes});
    exp_setup[3] = ev(0, 12'h100, v.rate);
    exp_setup[4] = ev(2, 12'd0, 8'h00);
    exp_setup[5] = ev(0, 12'h102, 8'h00);
    exp_setup[6] = ev(2, 12'd1, 8'h00);
    exp_setup[7] = ev(0, 12'h102, 8'h01);
    exp_setup[8] = ev(2, 12'd4, 8'h00);
    exp_setup[9] = ev(0, 12'h103, 8'h00);
    for (int i = 0; i < lg_n; i++) begin
      if (lg[i][21:20] == 2'd1) begin
        reads++; last_rd = i; if (first_rd < 0) first_rd = i;
      end
      if (lg[i][21:8] == {2'd0, 12'h103}) begin last_drv = int'(lg[i][7:0]); drv_w = i; end
      if (lg[i][21:8] == {2'd2, 12'd2} || lg[i][21:8] == {2'd2, 12'd3}) pat_i = i;
    end
    chk(done === 1'b1, "R11", "done raised", int'(done), 1);
    chk(pass === v.xpass && fail_code === v.code, code_req(v.code), "pass/code",
        int'({pass, fail_code}), int'({v.xpass, v.code}));
    ok = 1'b1;
    for (int i = 0; i < 6; i++) if (lg[i] !== exp_setup[i]) ok = 1'b0;
    chk(ok && lg_n >= 6, "R2", "setup order", int'(lg[2]), int'(exp_setup[2]));
    ok = 1'b1;
    for (int i = 6; i < 10; i++) if (lg[i] !== exp_setup[i]) ok = 1'b0;
    chk(ok, "R3", "clock recovery entry", int'(lg[8]), int'(exp_setup[8]));
    chk(first_rd > 0 && lg_cyc[first_rd] - lg_cyc[9] >= 500, "R3", "settle gap",
        first_rd > 0 ? lg_cyc[first_rd] - lg_cyc[9] : -1, 500);
    chk(reads == int'(v.reads), code_req(v.code), "status reads", reads, int'(v.reads));
    chk(last_drv == int'(v.drv), "R4", "last lane-set byte", last_drv, int'(v.drv));
    if (drv_w > 0)
      chk(lg[drv_w - 1] === ev(2, 12'd4, v.drv), "R4", "phy drive matches sink",
          int'(lg[drv_w - 1][7:0]), int'(v.drv));
    chk(lg_n >= 2 && lg[lg_n - 2] === ev(0, 12'h102, 8'h00) &&
        lg[lg_n - 1] === ev(2, 12'd5, 8'h00), "R11", "finish pair",
        int'(lg[lg_n - 1]), int'(ev(2, 12'd5, 8'h00)));
    chk(last_rd >= 0 && lg_cyc[lg_n - 2] - lg_cyc[last_rd] >= 400, "R11", "finish wait",
        last_rd >= 0 ? lg_cyc[lg_n - 2] - lg_cyc[last_rd] : -1, 400);
    if (v.code == 3'd0 || v.code == 3'd3)
      chk(pat_i > 0 && lg[pat_i] === ev(2, v.tps3 ? 12'd3 : 12'd2, 8'h00) &&
          lg[pat_i + 1] === ev(0, 12'h102, v.tps3 ? 8'h03 : 8'h02), "R8",
          "equalisation pattern", pat_i > 0 ? int'(lg[pat_i][9:8]) : -1,
          v.tps3 ? 3 : 2);
  endtask

  initial begin
    load_script(3'd0);
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && pass === 1'b0 && fail_code === 3'd0, "R1", "reset outputs",
        int'({done, pass, fail_code}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sreg_req && !phy_req && lg_n == 0, "R1", "idle without start", lg_n, 0);

    for (int k = 0; k < NV; k++) begin
      launch(VECS[k]);
      wait_done();
      check_run(VECS[k]);
    end

    // R12: a second start during a run is ignored
    launch(VECS[0]);
    repeat (40) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    begin
      int pw = 0;
      for (int i = 0; i < lg_n; i++) if (lg[i] === ev(0, 12'h600, 8'h01)) pw++;
      chk(pw == 1 && pass === 1'b1, "R12", "start while busy", pw, 1);
    end
    repeat (20) @(negedge clk);
    chk(!sreg_req && !phy_req && done, "R12", "stays idle after run",
        int'({sreg_req, phy_req}), 0);

    // R13: waits freeze without ticks
    us_tick = 1'b0;
    launch(VECS[5]);
    repeat (1500) @(negedge clk);
    begin
      int rd = 0;
      for (int i = 0; i < lg_n; i++) if (lg[i][21:20] == 2'd1) rd++;
      chk(rd == 0 && !done, "R13", "no read without tick", rd, 0);
    end
    us_tick = 1'b1;
    wait_done();
    chk(done && pass, "R13", "resumes with tick", int'(pass), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule